// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Read Controller

This block is the serial-side read engine of a byte-wide two-wire (I2C) EEPROM slave. The array has 16384 locations. The block samples SCL and SDA on the system clock and recognises START, repeated START and STOP. It checks the device address byte against a fixed family code and three strap inputs, and it can take in a two-byte word address. It then returns array bytes over SDA. The array itself is outside the block: the block presents a 14-bit address and reads back the byte at that address through a combinational read port.

Three kinds of read are supported. A random read starts as a write transfer that carries the two address bytes. A repeated START and a read-direction device byte follow, and the byte at the loaded address comes back. A current-address read skips the address bytes and returns the byte at the internal counter. In either case, when the master acknowledges a byte the next location is sent, and the counter wraps from the top of the array to zero. SDA leaves the block as an active-low pull-down enable for an open-drain pad.

Top module: `ee_rd_ctrl`

## Requirements
- R1: After reset, SDA is released (`sda_oe_n_o` = 1) and the internal address counter is 0, so a first current-address read returns the byte at address 0.
- R2: A falling SDA while SCL is high is a START, and this includes a repeated START in the middle of a transfer. A rising SDA while SCL is high is a STOP. After a STOP the block is idle with SDA released.
- R3: The device byte is 1010, then `strap_i[2:0]`, then the direction bit (1 = read), sent MSB first. On a mismatch the block does not acknowledge, keeps SDA released through every later bit, and ignores the bus until the next START.
- R4: The block acknowledges a matching device byte and each of the two word-address bytes by pulling SDA low during the ninth clock.
- R5: In a random read, the first address byte gives counter bits 13:8 from its bits 5:0. Its bits 7:6 are ignored. The second address byte gives bits 7:0.
- R6: Data bytes go out MSB first. The pull-down is enabled only for acknowledges and for 0 data bits, and the enable changes only while SCL is low.
- R7: Each time the master acknowledges a byte, the next byte sent comes from the previous address plus one.
- R8: Incrementing from address 16383 gives address 0, and output continues from there.
- R9: A NACK from the master ends the read with SDA released, and the counter then holds the last address sent plus one.
- R10: A read-direction device byte sent directly after START returns the byte at the current counter value, with no address bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Resolved serial data line level |
| strap_i | input | 3 | Device address strap bits |
| mem_rdata_i | input | 8 | Array byte at `mem_addr_o` |
| mem_addr_o | output | 14 | Internal address counter, array read address |
| sda_oe_n_o | output | 1 | Active-low open-drain pull-down enable for SDA |

## Verification
The embedded properties check three things on every cycle: the pull-down enable never moves while SCL stays high outside a START or STOP, every STOP leaves the block idle and released, and every START restarts the device-byte receiver. The counter properties check that each increment adds one and that address 16383 wraps to zero. Other behaviour shows only in whole bus transactions driven by the bench's scenarios. These are the address match and mismatch cases, the address bytes with their top two bits ignored, MSB-first data order, and the counter value that survives a NACK into the next current-address read.

// File: rtl/ee_rd_pkg.sv
package ee_rd_pkg;
    localparam logic [3:0] DEV_FAMILY = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_HOLD
    } rd_state_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_AH,
        PH_AL
    } rx_phase_e;

    typedef struct packed {
        rd_state_e  st;
        rx_phase_e  ph;
        logic [3:0] bits;
        logic [7:0] sh;
        logic       rd;
    } ctl_regs_t;
endpackage

// File: rtl/ee_bus_sense.sv
module ee_bus_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic cond_start,
    output logic cond_stop
);
    typedef struct packed {
        logic scl1;
        logic scl2;
        logic sda1;
        logic sda2;
    } sense_t;

    sense_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.scl1 = scl_i;
        s_d.scl2 = s_q.scl1;
        s_d.sda1 = sda_i;
        s_d.sda2 = s_q.sda1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_s      = s_q.scl1;
    assign sda_s      = s_q.sda1;
    assign scl_rise   = s_q.scl1 & ~s_q.scl2;
    assign scl_fall   = ~s_q.scl1 & s_q.scl2;
    assign cond_start = s_q.scl1 & s_q.scl2 & s_q.sda2 & ~s_q.sda1;
    assign cond_stop  = s_q.scl1 & s_q.scl2 & ~s_q.sda2 & s_q.sda1;
endmodule

// File: rtl/ee_addr_ctr.sv
module ee_addr_ctr #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi_i,
    input  logic              ld_lo_i,
    input  logic              inc_i,
    input  logic [ADDR_W-9:0] hi_i,
    input  logic [7:0]        lo_i,
    output logic [ADDR_W-1:0] cnt_o
);
    localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ld_hi_i)      cnt_d[ADDR_W-1:8] = hi_i;
        else if (ld_lo_i) cnt_d[7:0]        = lo_i;
        else if (inc_i)   cnt_d             = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R7
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !ld_hi_i && !ld_lo_i && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R8
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !ld_hi_i && !ld_lo_i && cnt_q == TOP) |=> (cnt_q == '0));
endmodule

// File: rtl/ee_rd_ctrl.sv
module ee_rd_ctrl
    import ee_rd_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    input  logic [7:0]        mem_rdata_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              sda_oe_n_o
);
    localparam logic [3:0] BYTE_BITS = 4'd8;
    localparam logic [3:0] LAST_BIT  = 4'd7;

    logic scl_s, sda_s, scl_rise, scl_fall, cond_start, cond_stop;
    logic ld_hi, ld_lo, inc;
    ctl_regs_t r_d, r_q;

    ee_bus_sense u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .cond_start (cond_start),
        .cond_stop  (cond_stop)
    );

    ee_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_hi_i (ld_hi),
        .ld_lo_i (ld_lo),
        .inc_i   (inc),
        .hi_i    (r_q.sh[ADDR_W-9:0]),
        .lo_i    (r_q.sh),
        .cnt_o   (mem_addr_o)
    );

    always_comb begin
        r_d   = r_q;
        ld_hi = 1'b0;
        ld_lo = 1'b0;
        inc   = 1'b0;
        if (cond_start) begin
            r_d.st   = ST_RX;
            r_d.ph   = PH_DEV;
            r_d.bits = '0;
            r_d.rd   = 1'b0;
        end else if (cond_stop) begin
            r_d.st = ST_IDLE;
        end else begin
            unique case (r_q.st)
                ST_RX: begin
                    if (scl_rise && r_q.bits < BYTE_BITS) begin
                        r_d.sh   = {r_q.sh[6:0], sda_s};
                        r_d.bits = r_q.bits + 4'd1;
                    end else if (scl_fall && r_q.bits == BYTE_BITS) begin
                        r_d.bits = '0;
                        unique case (r_q.ph)
                            PH_DEV: begin
                                if (r_q.sh[7:1] == {DEV_FAMILY, strap_i}) begin
                                    r_d.st = ST_ACK;
                                    r_d.rd = r_q.sh[0];
                                end else begin
                                    r_d.st = ST_IDLE;
                                end
                            end
                            PH_AH: begin
                                ld_hi  = 1'b1;
                                r_d.st = ST_ACK;
                            end
                            default: begin
                                ld_lo  = 1'b1;
                                r_d.st = ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        r_d.bits = '0;
                        if (r_q.rd) begin
                            r_d.st = ST_TX;
                            r_d.sh = mem_rdata_i;
                        end else if (r_q.ph == PH_AL) begin
                            r_d.st = ST_HOLD;
                        end else begin
                            r_d.st = ST_RX;
                            r_d.ph = (r_q.ph == PH_DEV) ? PH_AH : PH_AL;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (r_q.bits == LAST_BIT) begin
                            r_d.st   = ST_MACK;
                            r_d.bits = '0;
                            inc      = 1'b1;
                        end else begin
                            r_d.sh   = {r_q.sh[6:0], 1'b0};
                            r_d.bits = r_q.bits + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (!sda_s) r_d.bits = 4'd1;
                        else        r_d.st   = ST_IDLE;
                    end else if (scl_fall && r_q.bits == 4'd1) begin
                        r_d.st   = ST_TX;
                        r_d.sh   = mem_rdata_i;
                        r_d.bits = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.ph   <= PH_DEV;
            r_q.bits <= '0;
            r_q.sh   <= '0;
            r_q.rd   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_n_o = ~((r_q.st == ST_ACK) || (r_q.st == ST_TX && !r_q.sh[7]));

    // R6
    sda_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(cond_start) && !$past(cond_stop))
        |-> $stable(sda_oe_n_o));

    // R2
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond_stop |=> (r_q.st == ST_IDLE && sda_oe_n_o));

    // R2
    start_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond_start |=> (r_q.st == ST_RX && r_q.ph == PH_DEV && r_q.bits == 4'd0));
endmodule

// File: tb/sim_ee_rd_ctrl.sv
module sim_ee_rd_ctrl;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl = 1'b1;
    logic          sda_m = 1'b1;
    logic [2:0]    strap = 3'b101;
    logic          oe_n;
    logic          sda_line;
    logic [AW-1:0] maddr;
    logic [7:0]    mdat;
    int            total = 0;
    int            bad = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [AW-1:0] a);
        return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h5A;
    endfunction

    assign sda_line = sda_m & oe_n;
    assign mdat     = mem_f(maddr);

    ee_rd_ctrl #(.ADDR_W(AW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .strap_i     (strap),
        .mem_rdata_i (mdat),
        .mem_addr_o  (maddr),
        .sda_oe_n_o  (oe_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        scl = 1'b0; tick(4);
        sda_m = 1'b1; tick(4);
        scl = 1'b1; tick(8);
        sda_m = 1'b0; tick(8);
        scl = 1'b0; tick(4);
    endtask

    task automatic bus_stop();
        scl = 1'b0; tick(4);
        sda_m = 1'b0; tick(4);
        scl = 1'b1; tick(8);
        sda_m = 1'b1; tick(8);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(4);
        scl = 1'b1; tick(8);
        scl = 1'b0; tick(4);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(4);
        scl = 1'b1; tick(4);
        b = sda_line; tick(4);
        scl = 1'b0; tick(4);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ackbit);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ackbit);
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit more);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(more ? 1'b0 : 1'b1);
    endtask

    task automatic t_reset();
        tick(3);
        check(oe_n === 1'b1, "R1 released after reset", oe_n, 1);
    endtask

    // R10: current-address read; also R9 counter persistence
    task automatic t_current(input logic [AW-1:0] exp_a, input string req);
        logic       a;
        logic [7:0] v;
        bus_start();
        send_byte({4'b1010, strap, 1'b1}, a);
        check(a === 1'b0, "R4 R10 device ack on read", a, 0);
        recv_byte(v, 1'b0);
        check(v === mem_f(exp_a), req, v, mem_f(exp_a));
        check(oe_n === 1'b1, "R9 released after NACK", oe_n, 1);
        bus_stop();
        check(oe_n === 1'b1, "R2 released after STOP", oe_n, 1);
    endtask

    // R5 R7 R8: random read, then optional sequential bytes
    task automatic t_random(input logic [AW-1:0] base, input int n);
        logic          a;
        logic [7:0]    v;
        logic [AW-1:0] ea;
        bus_start();
        send_byte({4'b1010, strap, 1'b0}, a);
        check(a === 1'b0, "R4 device ack on write", a, 0);
        send_byte({2'b11, base[13:8]}, a);
        check(a === 1'b0, "R4 high address ack", a, 0);
        send_byte(base[7:0], a);
        check(a === 1'b0, "R4 low address ack", a, 0);
        bus_start();
        send_byte({4'b1010, strap, 1'b1}, a);
        check(a === 1'b0, "R2 ack after repeated START", a, 0);
        for (int i = 0; i < n; i++) begin
            ea = base + AW'(i);
            recv_byte(v, i < n - 1);
            if (i == 0)
                check(v === mem_f(ea), "R5 R6 first byte at loaded address", v, mem_f(ea));
            else if (ea == '0)
                check(v === mem_f(ea), "R8 wrap to address 0", v, mem_f(ea));
            else
                check(v === mem_f(ea), "R7 next sequential byte", v, mem_f(ea));
        end
        bus_stop();
    endtask

    // R3: address mismatch
    task automatic t_mismatch(input logic [7:0] devb);
        logic a;
        bus_start();
        send_byte(devb, a);
        check(a === 1'b1, "R3 no ack on mismatch", a, 1);
        send_byte(8'h00, a);
        check(a === 1'b1, "R3 still ignoring bus", a, 1);
        bus_stop();
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        t_reset();
        t_current(14'h0000, "R1 first read from address 0");
        t_random(14'h1234, 1);
        t_current(14'h1235, "R9 counter holds last plus one");
        t_random(14'h3FFE, 4);
        t_current(14'h0002, "R8 R9 counter after wrap");
        t_mismatch({4'b1010, 3'b010, 1'b1});
        t_mismatch({4'b1011, strap, 1'b1});
        t_current(14'h0003, "R3 counter untouched by mismatch");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule